// File: doc/BRIEF.md
# Hypervisor Translation Control Register

This block holds the 64-bit control word for a second-stage address translation unit. Every access carries the current privilege level. The block uses that level to decide the outcome of the access. It can read or write the register directly, raise an undefined-instruction flag, trap to level 2 with a syndrome class, or send the access to a memory location at a fixed offset.

The block also drives the effective configuration that the table walker uses. Several of these values differ from what software reads back:

- The two address-space selects are forced to non-secure under some conditions.
- Dirty-state management needs access-flag update to be on as well.
- The upper VMID byte is masked when the VMID width is 8 bits.
- The physical-size code is expanded into a count of address bits.

Top module: `s2_xlat_ctl_reg`

## Requirements
- R1: After a synchronous active-low reset the stored bits are all zero. A legal read returns 0x0000_0000_8000_0000.
- R2: Read data bits 63:32, 24:23 and 20 are always zero and cannot be changed by writes. Bit 31 reads as one in every legal read.
- R3: An access at privilege level 0 raises `acc_undef`, returns zero read data and leaves the register unchanged.
- R4: Accesses at levels 2 and 3 read the register or write it. A write takes effect at the next clock edge. Read data is zero during a write cycle.
- R5: At level 1, when `hyp_en`, `nest_en` and `nest_mem` are all 1, the access raises `redir_req` with `redir_off` = 0x040. The register is left unchanged.
- R6: At level 1, when `hyp_en` and `nest_en` are 1 and `nest_mem` is 0, the access raises `acc_trap` with `trap_syndrome` = 0x18. The register is left unchanged.
- R7: Every other level-1 case raises `acc_undef`. The register is left unchanged.
- R8: At most one of `acc_undef`, `acc_trap` and `redir_req` is high. None of them is high without `acc_vld`. The syndrome and the offset read zero when their flag is low.
- R9: The effective walk address-space select (`eff_walk_ns`) equals stored bit 29 OR `ns_state`.
- R10: The effective output address-space select (`eff_out_ns`) equals stored bit 30 OR `ns_state` OR stored bit 29 OR `sec_space_sel`.
- R11: `eff_af_en` equals stored bit 21. `eff_dirty_en` equals stored bit 22 AND stored bit 21.
- R12: `vmid_match` equals `vmid_in` when stored bit 19 is 1. Otherwise its upper 8 bits are forced to zero.
- R13: `eff_pa_bits` decodes stored bits 18:16 as follows: 0→32, 1→36, 2→40, 3→42, 4→44, 5→48, 6→52, 7→52.
- R14: When the parameter `VMID16_EN` is 0, bit 19 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_lvl | input | 2 | Privilege level of the access (0 to 3) |
| ns_state | input | 1 | Core is in non-secure state |
| hyp_en | input | 1 | Hypervisor level enabled in the current security state |
| nest_en | input | 1 | First nested-virtualization control bit |
| nest_mem | input | 1 | Second nested-virtualization control bit (memory redirect) |
| sec_space_sel | input | 1 | External secure-space select that forces the effective output space |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data (zero unless this is a legal read) |
| acc_undef | output | 1 | Undefined-instruction outcome |
| acc_trap | output | 1 | Trap-to-level-2 outcome |
| trap_syndrome | output | 6 | Syndrome class when trapping |
| redir_req | output | 1 | Redirect-to-memory outcome |
| redir_off | output | 12 | Memory offset for the redirect |
| vmid_in | input | 16 | VMID taken from the base register |
| vmid_match | output | 16 | VMID used for matching |
| eff_walk_ns | output | 1 | Effective walk address-space select |
| eff_out_ns | output | 1 | Effective output address-space select |
| eff_af_en | output | 1 | Effective access-flag update enable |
| eff_dirty_en | output | 1 | Effective dirty-state management enable |
| eff_pa_bits | output | 6 | Effective physical address width in bits |

## Verification
The hardest state to reach is `eff_out_ns` at 0. That needs secure state, stored bits 29 and 30 both zero, and the external select low, all at once. Reaching it means writing those bits as zero at level 2 or 3 while `ns_state` is 0. Each term is then raised in turn, one by one.

The level-1 decode needs all eight combinations of the three control bits. Each one is tried with a write of a pattern that differs from the stored value, so a leaked update would show in the next read. A long run of mixed accesses at random levels then checks every output against a reference model on every cycle.

// File: rtl/s2xc_pkg.sv
// Package: shared constants and types for the hypervisor translation control register.
// Assumes a 64-bit register. Field positions are fixed because the walker decodes them.
package s2xc_pkg;
    localparam int REG_W      = 64;
    localparam int SYN_W      = 6;
    localparam int OFF_W      = 12;
    localparam int PAB_W      = 6;
    localparam logic [SYN_W-1:0] TRAP_CLASS   = 6'h18;
    localparam logic [OFF_W-1:0] REDIR_OFFSET = 12'h040;

    // bit positions used by the effective-value logic
    localparam int B_OUT_NS  = 30;
    localparam int B_WALK_NS = 29;
    localparam int B_DIRTY   = 22;
    localparam int B_AF      = 21;
    localparam int B_VMIDW   = 19;
    localparam int B_PA_LO   = 16;

    // base write mask without the VMID width bit
    localparam logic [REG_W-1:0] BASE_WR_MASK = 64'h0000_0000_7E67_FFFF;
    localparam logic [REG_W-1:0] ONE_BIT31    = 64'h0000_0000_8000_0000;

    typedef enum logic [1:0] {
        ACC_DIRECT = 2'd0,
        ACC_UNDEF  = 2'd1,
        ACC_TRAP   = 2'd2,
        ACC_REDIR  = 2'd3
    } acc_kind_e;

    // expand a 3-bit physical-size code into address bits; code 7 behaves as the largest size
    function automatic logic [PAB_W-1:0] pa_code_to_bits(input logic [2:0] code);
        logic [PAB_W-1:0] r;
        unique case (code)
            3'd0:    r = 6'd32;
            3'd1:    r = 6'd36;
            3'd2:    r = 6'd40;
            3'd3:    r = 6'd42;
            3'd4:    r = 6'd44;
            3'd5:    r = 6'd48;
            default: r = 6'd52;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/s2xc_access_gate.sv
// Access gate: classifies each access by privilege level and the nested-virtualization bits.
// Purely combinational. Assumes the inputs are stable while acc_vld is high.
module s2xc_access_gate
    import s2xc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_vld,
    input  logic       acc_wr,
    input  logic [1:0] priv_lvl,
    input  logic       hyp_en,
    input  logic       nest_en,
    input  logic       nest_mem,
    output logic       direct_rd,
    output logic       direct_wr,
    output logic       out_undef,
    output logic       out_trap,
    output logic       out_redir
);
    acc_kind_e kind;

    // pick the outcome class from the privilege level and control bits
    always_comb begin
        kind = ACC_UNDEF;
        unique case (priv_lvl)
            2'd0: kind = ACC_UNDEF;
            2'd1: begin
                if (hyp_en && nest_en && nest_mem) kind = ACC_REDIR;
                else if (hyp_en && nest_en)        kind = ACC_TRAP;
                else                               kind = ACC_UNDEF;
            end
            default: kind = ACC_DIRECT;
        endcase
    end

    // qualify the class with the access strobe
    always_comb begin
        direct_rd = acc_vld && (kind == ACC_DIRECT) && !acc_wr;
        direct_wr = acc_vld && (kind == ACC_DIRECT) &&  acc_wr;
        out_undef = acc_vld && (kind == ACC_UNDEF);
        out_trap  = acc_vld && (kind == ACC_TRAP);
        out_redir = acc_vld && (kind == ACC_REDIR);
    end

    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_undef, out_trap, out_redir}));
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |-> !(out_undef || out_trap || out_redir || direct_wr || direct_rd));
    a_r3_pl0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && priv_lvl == 2'd0) |-> (out_undef && !direct_wr));
    a_r4_upper_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && priv_lvl[1]) |-> (direct_rd || direct_wr));
endmodule

// File: rtl/s2xc_store.sv
// Storage: holds the writable bits of the control word; cleared by synchronous active-low reset.
// Assumes wr_en is high only for legal direct writes. Bits outside the mask are held at zero.
module s2xc_store
    import s2xc_pkg::*;
#(
    parameter bit VMID16_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    localparam logic [REG_W-1:0] VMIDW_BIT = ONE_BIT31 >> (31 - B_VMIDW);
    localparam logic [REG_W-1:0] WR_MASK   = VMID16_EN ? (BASE_WR_MASK | VMIDW_BIT) : BASE_WR_MASK;

    // capture masked write data or clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata & WR_MASK;
    end

    a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~WR_MASK) == '0);
    a_r14_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        !VMID16_EN |-> !q[B_VMIDW]);
endmodule

// File: rtl/s2xc_effective.sv
// Effective-value decode: derives the walker controls from the stored bits and the core state.
// Combinational. Assumes cfg is the stored (masked) word, not the read-back value.
module s2xc_effective
    import s2xc_pkg::*;
#(
    parameter int VMID_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  cfg,
    input  logic              ns_state,
    input  logic              sec_space_sel,
    input  logic [VMID_W-1:0] vmid_in,
    output logic [VMID_W-1:0] vmid_match,
    output logic              eff_walk_ns,
    output logic              eff_out_ns,
    output logic              eff_af_en,
    output logic              eff_dirty_en,
    output logic [PAB_W-1:0]  eff_pa_bits
);
    localparam int HALF_W = VMID_W / 2;

    // address-space overrides and hardware-update enables
    always_comb begin
        eff_walk_ns  = cfg[B_WALK_NS] | ns_state;
        eff_out_ns   = cfg[B_OUT_NS] | ns_state | cfg[B_WALK_NS] | sec_space_sel;
        eff_af_en    = cfg[B_AF];
        eff_dirty_en = cfg[B_DIRTY] & cfg[B_AF];
        eff_pa_bits  = pa_code_to_bits(cfg[B_PA_LO +: 3]);
    end

    // VMID width selection for matching
    always_comb begin
        vmid_match = vmid_in;
        if (!cfg[B_VMIDW]) vmid_match[VMID_W-1:HALF_W] = '0;
    end

    a_r9_walk_ns: assert property (@(posedge clk) disable iff (!rst_n)
        ns_state |-> eff_walk_ns);
    a_r10_out_ns: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_state || sec_space_sel || eff_walk_ns) |-> eff_out_ns);
    a_r11_dirty_needs_af: assert property (@(posedge clk) disable iff (!rst_n)
        eff_dirty_en |-> eff_af_en);
    a_r12_vmid_low: assert property (@(posedge clk) disable iff (!rst_n)
        vmid_match[HALF_W-1:0] == vmid_in[HALF_W-1:0]);
    a_r13_pa_range: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_pa_bits >= 6'd32) && (eff_pa_bits <= 6'd52));
endmodule

// File: rtl/s2_xlat_ctl_reg.sv
// Top: hypervisor translation control register with privilege-gated access and effective outputs.
// Outcome flags are combinational and valid alongside acc_vld; writes land on the next clock edge.
module s2_xlat_ctl_reg
    import s2xc_pkg::*;
#(
    parameter bit VMID16_EN = 1'b1,
    parameter int VMID_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        priv_lvl,
    input  logic              ns_state,
    input  logic              hyp_en,
    input  logic              nest_en,
    input  logic              nest_mem,
    input  logic              sec_space_sel,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic [63:0]       acc_wdata,
    output logic [63:0]       acc_rdata,
    output logic              acc_undef,
    output logic              acc_trap,
    output logic [5:0]        trap_syndrome,
    output logic              redir_req,
    output logic [11:0]       redir_off,
    input  logic [VMID_W-1:0] vmid_in,
    output logic [VMID_W-1:0] vmid_match,
    output logic              eff_walk_ns,
    output logic              eff_out_ns,
    output logic              eff_af_en,
    output logic              eff_dirty_en,
    output logic [5:0]        eff_pa_bits
);
    logic             direct_rd, direct_wr;
    logic [REG_W-1:0] stored;
    logic [REG_W-1:0] rdback;

    s2xc_access_gate u_gate (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
        .priv_lvl(priv_lvl), .hyp_en(hyp_en), .nest_en(nest_en), .nest_mem(nest_mem),
        .direct_rd(direct_rd), .direct_wr(direct_wr),
        .out_undef(acc_undef), .out_trap(acc_trap), .out_redir(redir_req)
    );

    s2xc_store #(.VMID16_EN(VMID16_EN)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(direct_wr), .wdata(acc_wdata), .q(stored)
    );

    s2xc_effective #(.VMID_W(VMID_W)) u_eff (
        .clk(clk), .rst_n(rst_n), .cfg(stored), .ns_state(ns_state),
        .sec_space_sel(sec_space_sel), .vmid_in(vmid_in), .vmid_match(vmid_match),
        .eff_walk_ns(eff_walk_ns), .eff_out_ns(eff_out_ns), .eff_af_en(eff_af_en),
        .eff_dirty_en(eff_dirty_en), .eff_pa_bits(eff_pa_bits)
    );

    // read-back value: stored bits with the always-one bit applied
    always_comb rdback = stored | ONE_BIT31;

    // read data and side-band codes for the outcome flags
    always_comb begin
        acc_rdata     = direct_rd ? rdback : '0;
        trap_syndrome = acc_trap  ? TRAP_CLASS : '0;
        redir_off     = redir_req ? REDIR_OFFSET : '0;
    end

    a_r8_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && (acc_undef || acc_trap || redir_req)) |=> $stable(rdback));
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[63:32] == 32'h0);
    a_r2_bit31_one: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rdata != '0) |-> acc_rdata[31]);
    a_r6_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
        acc_trap |-> (trap_syndrome == 6'h18));
    a_r5_redir_code: assert property (@(posedge clk) disable iff (!rst_n)
        redir_req |-> (redir_off == 12'h040 && acc_rdata == '0));
endmodule

// File: tb/test_s2_xlat_ctl_reg.sv
// Bench: behavioural reference model compared against both instances on every clock.
module test_s2_xlat_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv_lvl = '0;
    logic        ns_state = 1'b0, hyp_en = 1'b0, nest_en = 1'b0, nest_mem = 1'b0;
    logic        sec_space_sel = 1'b0, acc_vld = 1'b0, acc_wr = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [15:0] vmid_in = '0;

    logic [63:0] rdata, rdata_n;
    logic        undef, trap, redir, undef_n, trap_n, redir_n;
    logic [5:0]  syn, syn_n, pab, pab_n;
    logic [11:0] roff, roff_n;
    logic [15:0] vm, vm_n;
    logic        wns, ons, af, dty, wns_n, ons_n, af_n, dty_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [63:0] m_wide = '0;
    logic [63:0] m_narrow = '0;

    always #5 clk = ~clk;

    s2_xlat_ctl_reg i_s2_xlat_ctl_reg (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .ns_state(ns_state), .hyp_en(hyp_en),
        .nest_en(nest_en), .nest_mem(nest_mem), .sec_space_sel(sec_space_sel),
        .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(rdata),
        .acc_undef(undef), .acc_trap(trap), .trap_syndrome(syn), .redir_req(redir),
        .redir_off(roff), .vmid_in(vmid_in), .vmid_match(vm), .eff_walk_ns(wns),
        .eff_out_ns(ons), .eff_af_en(af), .eff_dirty_en(dty), .eff_pa_bits(pab)
    );

    s2_xlat_ctl_reg #(.VMID16_EN(1'b0)) i_s2_xlat_ctl_reg_narrow (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .ns_state(ns_state), .hyp_en(hyp_en),
        .nest_en(nest_en), .nest_mem(nest_mem), .sec_space_sel(sec_space_sel),
        .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(rdata_n),
        .acc_undef(undef_n), .acc_trap(trap_n), .trap_syndrome(syn_n), .redir_req(redir_n),
        .redir_off(roff_n), .vmid_in(vmid_in), .vmid_match(vm_n), .eff_walk_ns(wns_n),
        .eff_out_ns(ons_n), .eff_af_en(af_n), .eff_dirty_en(dty_n), .eff_pa_bits(pab_n)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int pa_bits_of(input int code);
        case (code)
            0: return 32;
            1: return 36;
            2: return 40;
            3: return 42;
            4: return 44;
            5: return 48;
            default: return 52;
        endcase
    endfunction

    // compare all outputs of one instance against the model value m
    task automatic compare(input logic [63:0] m, input bit narrow);
        int kind; // 0 direct, 1 undef, 2 trap, 3 redirect
        logic [63:0] e_rd;
        logic [15:0] e_vm;
        logic [63:0] a_rd; logic a_un, a_tr, a_re, a_w, a_o, a_a, a_d;
        logic [5:0] a_sy, a_pb; logic [11:0] a_ro; logic [15:0] a_vm;
        if (narrow) begin
            a_rd = rdata_n; a_un = undef_n; a_tr = trap_n; a_re = redir_n; a_sy = syn_n;
            a_ro = roff_n; a_vm = vm_n; a_w = wns_n; a_o = ons_n; a_a = af_n; a_d = dty_n; a_pb = pab_n;
        end else begin
            a_rd = rdata; a_un = undef; a_tr = trap; a_re = redir; a_sy = syn;
            a_ro = roff; a_vm = vm; a_w = wns; a_o = ons; a_a = af; a_d = dty; a_pb = pab;
        end
        if (priv_lvl >= 2) kind = 0;
        else if (priv_lvl == 0) kind = 1;
        else if (hyp_en && nest_en && nest_mem) kind = 3;
        else if (hyp_en && nest_en) kind = 2;
        else kind = 1;
        e_rd = (acc_vld && kind == 0 && !acc_wr) ? (m | 64'h8000_0000) : 64'h0;
        chk(priv_lvl == 0 ? "R3" : (priv_lvl == 1 ? "R7" : "R4"), "rdata", a_rd, e_rd);
        chk(priv_lvl == 0 ? "R3" : "R7", "undef", 64'(a_un), 64'(acc_vld && kind == 1));
        chk("R6", "trap", 64'(a_tr), 64'(acc_vld && kind == 2));
        chk("R6", "syndrome", 64'(a_sy), (acc_vld && kind == 2) ? 64'h18 : 64'h0);
        chk("R5", "redir", 64'(a_re), 64'(acc_vld && kind == 3));
        chk("R8", "offset", 64'(a_ro), (acc_vld && kind == 3) ? 64'h40 : 64'h0);
        chk("R9", "walk_ns", 64'(a_w), 64'(m[29] || ns_state));
        chk("R10", "out_ns", 64'(a_o), 64'(m[30] || m[29] || ns_state || sec_space_sel));
        chk("R11", "af", 64'(a_a), 64'(m[21]));
        chk("R11", "dirty", 64'(a_d), 64'(m[22] && m[21]));
        e_vm = m[19] ? vmid_in : {8'h00, vmid_in[7:0]};
        chk("R12", "vmid", 64'(a_vm), 64'(e_vm));
        chk("R13", "pa_bits", 64'(a_pb), 64'(pa_bits_of(int'(m[18:16]))));
    endtask

    // one clock of stimulus: drive, compare, then advance the model
    task automatic step(input int pl, input bit ns, input bit hyp, input bit nv, input bit nv2,
                        input bit sel, input bit vld, input bit wr, input logic [63:0] wd,
                        input logic [15:0] vmid);
        @(negedge clk);
        priv_lvl = 2'(pl); ns_state = ns; hyp_en = hyp; nest_en = nv; nest_mem = nv2;
        sec_space_sel = sel; acc_vld = vld; acc_wr = wr; acc_wdata = wd; vmid_in = vmid;
        #2;
        compare(m_wide, 1'b0);
        compare(m_narrow, 1'b1);
        if (vld && wr && pl >= 2) begin
            m_wide   = wd & 64'h0000_0000_7E6F_FFFF;
            m_narrow = wd & 64'h0000_0000_7E67_FFFF;
        end
    endtask

    task automatic rd(input int pl, input bit ns, input bit sel, input logic [15:0] vmid);
        step(pl, ns, 1'b0, 1'b0, 1'b0, sel, 1'b1, 1'b0, 64'h0, vmid);
    endtask

    task automatic wrr(input int pl, input logic [63:0] d);
        step(pl, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, d, 16'h0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog expired act=%0d exp<20000", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset, then read the cleared value
        repeat (3) @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
        rd(2, 1'b0, 1'b0, 16'hABCD);
        chk("R1", "reset read", rdata, 64'h0000_0000_8000_0000);

        // R2, R14: write all ones at level 2, check the masks
        wrr(2, '1);
        rd(3, 1'b0, 1'b0, 16'hFFFF);
        chk("R2", "masked read", rdata, 64'h0000_0000_FE6F_FFFF);
        chk("R14", "narrow read", rdata_n, 64'h0000_0000_FE67_FFFF);

        // R3: level 0 write is undefined and changes nothing
        step(0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0, 16'h0);
        rd(2, 1'b0, 1'b0, 16'h0);
        chk("R3", "no update", rdata, 64'h0000_0000_FE6F_FFFF);

        // R5, R6, R7: all eight level-1 control combinations with a write of zero
        for (int c = 0; c < 8; c++) begin
            step(1, 1'b0, c[0], c[1], c[2], 1'b0, 1'b1, 1'b1, 64'h0, 16'h0);
            rd(2, 1'b0, 1'b0, 16'h0);
            chk("R8", "level1 no update", rdata, 64'h0000_0000_FE6F_FFFF);
        end

        // R10: secure state with both space bits clear, then raise each term
        wrr(2, 64'h0000_0000_0003_0000);
        rd(2, 1'b0, 1'b0, 16'h1234);
        chk("R10", "out_ns low", 64'(ons), 64'h0);
        rd(2, 1'b0, 1'b1, 16'h1234);
        rd(2, 1'b1, 1'b0, 16'h1234);
        wrr(3, 64'h0000_0000_2000_0000);
        rd(2, 1'b0, 1'b0, 16'h1234);
        chk("R9", "walk stored", 64'(wns), 64'h1);
        wrr(3, 64'h0000_0000_4000_0000);
        rd(2, 1'b0, 1'b0, 16'h1234);
        chk("R10", "out stored", 64'(ons), 64'h1);

        // R11, R12, R13: sweep the hardware-update bits, VMID width and size code
        for (int p = 0; p < 8; p++) begin
            for (int h = 0; h < 4; h++) begin
                wrr(2, (64'(p) << 16) | (64'(h) << 21) | (64'(p[0]) << 19));
                rd(2, 1'b0, 1'b0, 16'hC35A);
            end
        end
        // idle cycles: outcome flags stay low
        for (int k = 0; k < 4; k++) step(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 16'h0);

        // mixed accesses at random levels
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r = $urandom;
            step(int'(r[1:0]), r[2], r[3], r[4], r[5], r[6], r[7], r[8],
                 {$urandom, $urandom}, 16'($urandom));
        end
        finish_run();
    end
endmodule